// File: doc/BRIEF.md
# Serial CRC-16 Generator

This block computes a 16-bit cyclic redundancy check over a message that arrives one bit per clock. A 16-stage shift register runs with XOR feedback for the generator polynomial x^16 + x^15 + x^2 + 1. Each clock on which the strobe is high takes in one message bit, and the register advances one step of polynomial division. The current remainder is always visible on a parallel output.

A transmitter or receiver pulses `init` before a message, so that the register starts from all ones. It then presents message bits in transmission order, with the strobe marking each valid bit. The strobe may drop between bits. After the last bit, the output holds the check value. It is neither inverted nor bit-reversed. A receiver compares this value with the received check field.

Top module: `crc16_serial`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the register is loaded with 16'hFFFF. `crc_out` reads 16'hFFFF from that edge on.
- R2: A clock edge with `init` high loads the register with 16'hFFFF. It takes effect in the cycle after `init` is sampled.
- R3: When `init` and `bit_valid` are both high at one edge, the preset wins and the data bit on `bit_in` is discarded.
- R4: With `init` and `bit_valid` both low, the register keeps its value, whatever `bit_in` carries.
- R5: On a valid edge, let f = `bit_in` XOR `crc_out[15]`. The register then takes the following values:
  - bit 0 takes f;
  - bit 2 takes bit 1 XOR f;
  - bit 15 takes bit 14 XOR f;
  - every other bit i takes bit i-1.

  Bits are consumed in the order they are strobed.
- R6: After a preset and N strobed bits, `crc_out` equals the remainder of the division by 0x18005 of (0xFFFF times x^N) plus (the message times x^16). The first strobed bit is the highest-order message coefficient. No output inversion or reflection is applied.
- R7: Take a message that is not changed in the check field. Altering one bit, two bits, or any burst of fewer than 16 bits in it changes the final `crc_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low, presets the register |
| init | input | 1 | Synchronous preset to all ones, wins over data |
| bit_valid | input | 1 | High when `bit_in` carries a message bit |
| bit_in | input | 1 | Serial message bit |
| crc_out | output | 16 | Current remainder, bit 15 the highest-order coefficient |

## Verification
A preset and a data bit can fall on the same edge. The bench provokes this by raising `init` together with `bit_valid`, both in the middle of a message and at its start, with `bit_in` driven to both values. It then expects the all-ones value in the following cycle, with no trace of that bit. The behavioural reference model runs a long division over the queued message bits after every clock. It clears its queue on such a collision, so any leakage of the colliding bit shows up as a mismatch on the next compare.

// File: rtl/crc16_serial.sv
module crc16_serial #(
  parameter int              WIDTH = 16,
  parameter logic [WIDTH-1:0] POLY  = 16'h8005,
  parameter logic [WIDTH-1:0] SEED  = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             bit_valid,
  input  logic             bit_in,
  output logic [WIDTH-1:0] crc_out
);

  logic [WIDTH-1:0] lfsr_q;
  logic [WIDTH-1:0] lfsr_d;
  logic             fb;

  assign fb = bit_in ^ lfsr_q[WIDTH-1];

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_stage
      if (gi == 0) begin : g_head
        assign lfsr_d[gi] = POLY[gi] & fb;
      end else if (POLY[gi]) begin : g_tap
        assign lfsr_d[gi] = lfsr_q[gi-1] ^ fb;
      end else begin : g_plain
        assign lfsr_d[gi] = lfsr_q[gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || init)
      lfsr_q <= SEED;
    else if (bit_valid)
      lfsr_q <= lfsr_d;
  end

  assign crc_out = lfsr_q;

endmodule

// File: rtl/crc16_serial_chk.sv
module crc16_serial_chk #(
  parameter int              WIDTH = 16,
  parameter logic [WIDTH-1:0] POLY  = 16'h8005,
  parameter logic [WIDTH-1:0] SEED  = 16'hFFFF
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init,
  input logic             bit_valid,
  input logic             bit_in,
  input logic [WIDTH-1:0] crc_out
);

  p_init_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> crc_out == SEED);

  p_init_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (init && bit_valid) |=> crc_out == SEED);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !bit_valid) |=> $stable(crc_out));

  p_head_fb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && bit_valid) |=> crc_out[0] == $past(bit_in ^ crc_out[WIDTH-1]));

  p_shift_taps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && bit_valid) |=> crc_out[WIDTH-1:1] ==
      ($past(crc_out[WIDTH-2:0]) ^
       ({(WIDTH-1){$past(bit_in ^ crc_out[WIDTH-1])}} & POLY[WIDTH-1:1])));

endmodule

bind crc16_serial crc16_serial_chk #(
  .WIDTH(WIDTH), .POLY(POLY), .SEED(SEED)
) u_chk (
  .clk(clk), .rst_n(rst_n), .init(init), .bit_valid(bit_valid),
  .bit_in(bit_in), .crc_out(crc_out)
);

// File: tb/crc16_serial_tb.sv
module crc16_serial_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init = 1'b0;
  logic        bit_valid = 1'b0;
  logic        bit_in = 1'b0;
  logic [15:0] crc_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit msg[$];

  localparam logic [16:0] GEN  = 17'h18005;
  localparam logic [15:0] PRE  = 16'hFFFF;

  always #2 clk = ~clk;

  crc16_serial u_dut (
    .clk(clk), .rst_n(rst_n), .init(init), .bit_valid(bit_valid),
    .bit_in(bit_in), .crc_out(crc_out)
  );

  function automatic logic [15:0] ref_rem(input bit q[$]);
    int n = q.size();
    bit d[];
    logic [15:0] r;
    d = new[n + 16];
    for (int k = 0; k < n + 16; k++) d[k] = 1'b0;
    for (int k = 0; k < 16; k++) d[n + k] = PRE[k];
    for (int j = 0; j < n; j++) d[16 + n - 1 - j] ^= q[j];
    for (int k = n + 15; k >= 16; k--)
      if (d[k])
        for (int t = 0; t <= 16; t++) d[k - 16 + t] ^= GEN[t];
    for (int k = 0; k < 16; k++) r[k] = d[k];
    return r;
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_ne(input logic [15:0] act, input logic [15:0] other, input string tag);
    checks++;
    if (act === other) begin
      fails++;
      $display("FAIL %s: actual %h expected a value other than %h", tag, act, other);
    end
  endtask

  task automatic step(input logic r, input logic i, input logic v, input logic b,
                      input string tag);
    rst_n = !r; init = i; bit_valid = v; bit_in = b;
    @(posedge clk);
    if (r || i) msg.delete();
    else if (v) msg.push_back(b);
    @(negedge clk);
    check(crc_out, ref_rem(msg), tag);
  endtask

  task automatic feed(input logic [63:0] data, input int n, input bit gaps,
                      input string tag);
    for (int k = n - 1; k >= 0; k--) begin
      step(1'b0, 1'b0, 1'b1, data[k], tag);
      if (gaps && (k % 5 == 0)) step(1'b0, 1'b0, 1'b0, ~data[k], "R4 gap");
    end
  endtask

  task automatic run_msg(input logic [63:0] data, input int n, output logic [15:0] res);
    step(1'b0, 1'b1, 1'b0, 1'b0, "R2 preset");
    feed(data, n, 1'b0, "R6 message");
    res = crc_out;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] clean, bad;
    logic [63:0] base;
    @(negedge clk);
    for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 1'b1, 1'b1, "R1 reset");
    check(crc_out, 16'hFFFF, "R1 reset value");

    feed(64'h3132333435363738, 64, 1'b0, "R5 R6 ascii pattern");
    for (int k = 0; k < 6; k++) step(1'b0, 1'b0, 1'b0, k[0], "R4 idle hold");

    step(1'b0, 1'b1, 1'b0, 1'b0, "R2 preset mid-stream");
    check(crc_out, 16'hFFFF, "R2 preset value");
    feed(64'h0, 20, 1'b0, "R6 zeros");
    feed(64'hFFFFF, 20, 1'b1, "R6 ones with gaps");

    step(1'b0, 1'b1, 1'b1, 1'b1, "R3 init with valid one");
    check(crc_out, 16'hFFFF, "R3 bit discarded");
    feed(64'hA5, 8, 1'b0, "R5 after collision");
    step(1'b0, 1'b1, 1'b1, 1'b0, "R3 init with valid zero");
    step(1'b0, 1'b1, 1'b1, 1'b1, "R3 back-to-back collision");

    for (int m = 0; m < 12; m++) begin
      base = {$urandom, $urandom};
      step(1'b0, 1'b1, 1'b0, 1'b0, "R2 preset");
      feed(base, 8 + (m * 4), m[0], "R6 random message");
    end

    feed(64'hDEADBEEF, 32, 1'b0, "R5 before reset");
    step(1'b1, 1'b0, 1'b1, 1'b0, "R1 reset mid-stream");
    check(crc_out, 16'hFFFF, "R1 reset mid-stream value");

    base = 64'h0000_C3A5_96F0_1E7D;
    run_msg(base, 48, clean);
    for (int p = 0; p < 48; p += 7) begin
      run_msg(base ^ (64'h1 << p), 48, bad);
      check_ne(bad, clean, "R7 single-bit error");
    end
    for (int p = 0; p < 40; p += 9) begin
      run_msg(base ^ (64'h1 << p) ^ (64'h1 << (p + 8)), 48, bad);
      check_ne(bad, clean, "R7 double-bit error");
    end
    for (int len = 2; len < 16; len += 3) begin
      run_msg(base ^ ((64'h1 | (64'h1 << (len - 1)) | (64'h5 << 1)) << 20), 48, bad);
      check_ne(bad, clean, "R7 burst error");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule